// File: doc/BRIEF.md
# Light-Load Pulse-Skip Controller

This controller sits beside the fixed-frequency modulator of a synchronous buck converter. It decides when the converter should stop switching on every cycle and start pulse-skipping, and when it should return. All analog decisions reach it as single-bit flags that are already synchronous to the system clock `clk`. Those flags are the zero-current crossing of the low-side switch, output above the upper band, output at or below nominal, output below the exit band, and the skip peak-current limit. The switching clock `pwm_clk` is sampled as a level, and its rising edge is detected inside the block.

In PWM mode the high-side request follows the modulator's duty command and the low side takes the complement, so the inductor current may go negative. Meanwhile a counter watches for an unbroken run of crossing cycles. When the run is complete the block enters skip mode. In skip mode each pulse starts on a switching-clock edge and ends on the over-voltage flag or on the current-limit flag. The low side then conducts until the current reaches zero. After that both switches rest and the switching clock is gated off until the output droops back to nominal. Both switch enables pass through a dead-time stage, so they never overlap.

Top module: `pskip_ctrl`

## Requirements
- R1: Skip mode (`skip_mode`=1) can only be entered while `skip_en`=1. If `skip_en` is 0 during skip mode, `skip_mode` is 0 after the next `clk` edge.
- R2: A switching cycle counts as crossing if `zc_flag` was high in any `clk` cycle since the previous `pwm_clk` rising edge, including the clock cycle of the edge. `skip_mode` rises one `clk` edge after the rising edge that completes the eighth consecutive crossing cycle. The state then has both switches off and `clk_gate_en`=0.
- R3: A switching cycle without a crossing clears the run count.
- R4: In PWM mode `hs_req` follows `pwm_hs_cmd` and `ls_en` follows its complement, each subject to dead time.
- R5: In skip mode with the clock enabled, a `pwm_clk` rising edge launches a pulse: `hs_req` is 1 two `clk` edges later.
- R6: `ov_flag` or `ipk_flag` during a pulse ends it. `hs_req` is 0 two edges later, and `ls_en` rises one edge after that.
- R7: After a pulse, `ls_en` stays high until `zc_flag`. One edge after `zc_flag`, `clk_gate_en` is 0, and the next edge clears `ls_en`. `pwm_clk` edges are ignored while `clk_gate_en`=0.
- R8: `below_nom` in the resting state sets `clk_gate_en` after one edge, and the next `pwm_clk` rising edge launches a pulse.
- R9: `below_exit` in skip mode returns the block to PWM after one edge. This takes priority over a pulse launch in the same cycle.
- R10: Any return to PWM clears the run count, so re-entry needs eight fresh crossing cycles.
- R11: `hs_req` and `ls_en` are never high together. Between one falling and the other rising there is at least one `clk` cycle with both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| skip_en | input | 1 | Permits pulse-skip operation |
| pwm_clk | input | 1 | Switching clock level, synchronous to clk |
| pwm_hs_cmd | input | 1 | High-side command from the fixed-frequency modulator |
| zc_flag | input | 1 | Low-side current has crossed zero |
| ov_flag | input | 1 | Output above the upper skip band |
| below_nom | input | 1 | Output at or below nominal |
| below_exit | input | 1 | Output below the exit band |
| ipk_flag | input | 1 | Skip peak-current limit reached |
| hs_req | output | 1 | High-side switch request |
| ls_en | output | 1 | Low-side switch enable |
| clk_gate_en | output | 1 | Switching-clock enable |
| skip_mode | output | 1 | High while in pulse-skip mode |

## Verification
The collision that matters is a pulse launch and an exit to PWM arriving in the same cycle. The bench arms a pulse with `below_nom`, then raises `pwm_clk` and `below_exit` on the same clock. It judges the result by `skip_mode` falling after one edge and `hs_req` staying low, as the PWM command is low. The entry counter is swept over every ten-cycle pattern of crossing and missing cycles, and the entry point is predicted from a run-length model. A continuous monitor judges dead-time overlap on every cycle.

// File: rtl/pskip_pkg.sv
package pskip_pkg;
  typedef enum logic [2:0] {
    ST_PWM   = 3'd0,
    ST_ARM   = 3'd1,
    ST_HS    = 3'd2,
    ST_LS    = 3'd3,
    ST_DROOP = 3'd4
  } pskip_state_e;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;
endpackage

// File: rtl/pskip_zc_qual.sv
module pskip_zc_qual #(
  parameter int ZC_RUN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_clk,
  input  logic zc_flag,
  input  logic count_en,
  output logic pwm_rise,
  output logic run_done
);
  localparam int CNT_W = (ZC_RUN > 2) ? $clog2(ZC_RUN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ZC_RUN - 1);

  logic             pwm_q;
  logic             zc_seen;
  logic             crossed;
  logic [CNT_W-1:0] run_cnt;

  assign pwm_rise = pwm_clk & ~pwm_q;
  assign crossed  = zc_seen | zc_flag;
  assign run_done = count_en & pwm_rise & crossed & (run_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= pwm_clk;
    end
  end

  // Sticky crossing record per switching cycle and the run-length counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_seen <= 1'b0;
      run_cnt <= '0;
    end else if (!count_en) begin
      zc_seen <= 1'b0;
      run_cnt <= '0;
    end else if (pwm_rise) begin
      zc_seen <= 1'b0;
      if (!crossed || run_cnt == LAST) begin
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end else begin
      zc_seen <= crossed;
    end
  end
endmodule

// File: rtl/pskip_fsm.sv
module pskip_fsm
  import pskip_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         skip_en,
  input  logic         pwm_hs_cmd,
  input  logic         pwm_rise,
  input  logic         run_done,
  input  logic         ov_flag,
  input  logic         ipk_flag,
  input  logic         zc_flag,
  input  logic         below_nom,
  input  logic         below_exit,
  output pskip_state_e state,
  output phase_e       phase_req
);
  pskip_state_e state_n;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_PWM:   if (skip_en && run_done) state_n = ST_DROOP;
      ST_ARM:   if (pwm_rise) state_n = ST_HS;
      ST_HS:    if (ov_flag || ipk_flag) state_n = ST_LS;
      ST_LS:    if (zc_flag) state_n = ST_DROOP;
      ST_DROOP: if (below_nom) state_n = ST_ARM;
      default:  state_n = ST_PWM;
    endcase
    // Leaving skip mode outranks every transition inside it
    if (state != ST_PWM && (below_exit || !skip_en)) begin
      state_n = ST_PWM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_PWM;
    end else begin
      state <= state_n;
    end
  end

  always_comb begin
    unique case (state)
      ST_PWM:  phase_req = pwm_hs_cmd ? PH_HIGH : PH_LOW;
      ST_HS:   phase_req = PH_HIGH;
      ST_LS:   phase_req = PH_LOW;
      default: phase_req = PH_OFF;
    endcase
  end
endmodule

// File: rtl/pskip_deadtime.sv
module pskip_deadtime
  import pskip_pkg::*;
#(
  parameter int DEAD_CYC = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase_req,
  output logic   hs_o,
  output logic   ls_o
);
  localparam int GAP_W = $clog2(DEAD_CYC + 1);

  logic [GAP_W-1:0] gap;
  logic             gap_ok;
  logic             want_hs;
  logic             want_ls;

  assign want_hs = (phase_req == PH_HIGH);
  assign want_ls = (phase_req == PH_LOW);
  // The current all-off cycle counts toward the gap
  assign gap_ok  = (int'(gap) + 1) >= DEAD_CYC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_o <= 1'b0;
      ls_o <= 1'b0;
      gap  <= '0;
    end else begin
      if (hs_o || ls_o) begin
        gap  <= '0;
        hs_o <= hs_o & want_hs;
        ls_o <= ls_o & want_ls;
      end else begin
        if (int'(gap) < DEAD_CYC) gap <= gap + 1'b1;
        if (gap_ok) begin
          hs_o <= want_hs;
          ls_o <= want_ls;
        end
      end
    end
  end
endmodule

// File: rtl/pskip_ctrl.sv
module pskip_ctrl
  import pskip_pkg::*;
#(
  parameter int ZC_RUN   = 8,
  parameter int DEAD_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic skip_en,
  input  logic pwm_clk,
  input  logic pwm_hs_cmd,
  input  logic zc_flag,
  input  logic ov_flag,
  input  logic below_nom,
  input  logic below_exit,
  input  logic ipk_flag,
  output logic hs_req,
  output logic ls_en,
  output logic clk_gate_en,
  output logic skip_mode
);
  pskip_state_e state;
  phase_e       phase_req;
  logic         pwm_rise;
  logic         run_done;
  logic         count_en;

  assign count_en = skip_en && (state == ST_PWM);

  pskip_zc_qual #(.ZC_RUN(ZC_RUN)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_clk  (pwm_clk),
    .zc_flag  (zc_flag),
    .count_en (count_en),
    .pwm_rise (pwm_rise),
    .run_done (run_done)
  );

  pskip_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .skip_en    (skip_en),
    .pwm_hs_cmd (pwm_hs_cmd),
    .pwm_rise   (pwm_rise),
    .run_done   (run_done),
    .ov_flag    (ov_flag),
    .ipk_flag   (ipk_flag),
    .zc_flag    (zc_flag),
    .below_nom  (below_nom),
    .below_exit (below_exit),
    .state      (state),
    .phase_req  (phase_req)
  );

  pskip_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dt (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_req (phase_req),
    .hs_o      (hs_req),
    .ls_o      (ls_en)
  );

  assign skip_mode   = (state != ST_PWM);
  assign clk_gate_en = (state != ST_DROOP);
endmodule

// File: rtl/pskip_ctrl_chk.sv
module pskip_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic skip_en,
  input logic below_exit,
  input logic hs_req,
  input logic ls_en,
  input logic clk_gate_en,
  input logic skip_mode
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_req && ls_en)); // R11
  AST_HS_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_req) |-> !$past(ls_en)); // R11
  AST_LS_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> !$past(hs_req)); // R11
  AST_SKIP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !skip_en |=> !skip_mode); // R1
  AST_EXIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_mode && below_exit) |=> !skip_mode); // R9
  AST_GATE_IN_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_gate_en |-> skip_mode); // R7
endmodule

bind pskip_ctrl pskip_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .skip_en     (skip_en),
  .below_exit  (below_exit),
  .hs_req      (hs_req),
  .ls_en       (ls_en),
  .clk_gate_en (clk_gate_en),
  .skip_mode   (skip_mode)
);

// File: tb/pskip_ctrl_tb_top.sv
module pskip_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic skip_en = 1'b0, pwm_clk = 1'b0, pwm_hs_cmd = 1'b0, zc_flag = 1'b0;
  logic ov_flag = 1'b0, below_nom = 1'b0, below_exit = 1'b0, ipk_flag = 1'b0;
  logic hs_req, ls_en, clk_gate_en, skip_mode;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  pskip_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .skip_en(skip_en), .pwm_clk(pwm_clk),
    .pwm_hs_cmd(pwm_hs_cmd), .zc_flag(zc_flag), .ov_flag(ov_flag),
    .below_nom(below_nom), .below_exit(below_exit), .ipk_flag(ipk_flag),
    .hs_req(hs_req), .ls_en(ls_en), .clk_gate_en(clk_gate_en),
    .skip_mode(skip_mode)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {pwm_clk, pwm_hs_cmd, zc_flag, ov_flag, below_nom, below_exit, ipk_flag} = '0;
    edges(2);
    rst_n = 1'b1;
    edges(1);
  endtask

  // One switching cycle; returns one edge after the rising edge
  task automatic sw_cycle(input logic zc);
    pwm_clk = 1'b0;
    zc_flag = zc;
    edges(1);
    zc_flag = 1'b0;
    edges(1);
    pwm_clk = 1'b1;
    edges(1);
  endtask

  // R11 monitor on every cycle
  logic hs_prev = 1'b0, ls_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(hs_req & ls_en, 1'b0, "R11 overlap");
      if (hs_req && !hs_prev) chk(ls_prev, 1'b0, "R11 gap before hs");
      if (ls_en && !ls_prev) chk(hs_prev, 1'b0, "R11 gap before ls");
    end
    hs_prev = hs_req;
    ls_prev = ls_en;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // Reset state
    rst_n = 1'b0;
    edges(1);
    chk(hs_req, 1'b0, "reset hs_req");
    chk(ls_en, 1'b0, "reset ls_en");
    chk(skip_mode, 1'b0, "reset skip_mode");
    chk(clk_gate_en, 1'b1, "reset clk_gate_en");

    // R2 R3: sweep all ten-cycle crossing patterns against a run model
    for (int p = 0; p < 1024; p++) begin
      int  run;
      bit  in_skip;
      do_reset();
      skip_en = 1'b1;
      run = 0;
      in_skip = 1'b0;
      for (int i = 0; i < 10; i++) begin
        logic b;
        b = p[i];
        sw_cycle(b);
        if (!in_skip) begin
          run = b ? run + 1 : 0;
          if (run == 8) in_skip = 1'b1;
        end
        chk(skip_mode, in_skip, "R2 R3 entry after run of 8");
        chk(clk_gate_en, !in_skip, "R2 gated at entry");
      end
    end

    // R1: disabled skip never entered
    do_reset();
    skip_en = 1'b0;
    for (int i = 0; i < 10; i++) sw_cycle(1'b1);
    chk(skip_mode, 1'b0, "R1 disabled");

    // Enter skip; R7 edges ignored while gated
    skip_en = 1'b1;
    for (int i = 0; i < 8; i++) sw_cycle(1'b1);
    chk(skip_mode, 1'b1, "R2 entered");
    edges(1);
    chk(ls_en, 1'b0, "R2 both off at rest");
    sw_cycle(1'b0);
    edges(2);
    chk(hs_req, 1'b0, "R7 gated edge ignored");

    // R8 R5 R6 R7: one full pulse ended by over-voltage
    pwm_clk = 1'b0;
    below_nom = 1'b1;
    edges(1);
    below_nom = 1'b0;
    chk(clk_gate_en, 1'b1, "R8 clock re-enabled");
    pwm_clk = 1'b1;
    edges(1);
    chk(hs_req, 1'b0, "R5 hs one edge after rise");
    edges(1);
    chk(hs_req, 1'b1, "R5 hs two edges after rise");
    chk(ls_en, 1'b0, "R5 ls off in pulse");
    ov_flag = 1'b1;
    edges(1);
    chk(hs_req, 1'b1, "R6 hs one edge after ov");
    edges(1);
    ov_flag = 1'b0;
    chk(hs_req, 1'b0, "R6 hs off two edges after ov");
    chk(ls_en, 1'b0, "R11 dead cycle");
    edges(1);
    chk(ls_en, 1'b1, "R6 ls on after dead cycle");
    edges(3);
    chk(ls_en, 1'b1, "R7 ls holds until zero cross");
    zc_flag = 1'b1;
    edges(1);
    zc_flag = 1'b0;
    chk(clk_gate_en, 1'b0, "R7 clock gated after zc");
    edges(1);
    chk(ls_en, 1'b0, "R7 ls off after zc");

    // R6: pulse ended by current limit
    pwm_clk = 1'b0;
    below_nom = 1'b1;
    edges(1);
    below_nom = 1'b0;
    pwm_clk = 1'b1;
    edges(2);
    chk(hs_req, 1'b1, "R6 second pulse on");
    ipk_flag = 1'b1;
    edges(2);
    ipk_flag = 1'b0;
    chk(hs_req, 1'b0, "R6 ipk ends pulse");
    edges(1);
    zc_flag = 1'b1;
    edges(1);
    zc_flag = 1'b0;
    edges(1);

    // R9: exit collides with pulse launch
    pwm_clk = 1'b0;
    below_nom = 1'b1;
    edges(1);
    below_nom = 1'b0;
    pwm_clk = 1'b1;
    below_exit = 1'b1;
    edges(1);
    below_exit = 1'b0;
    chk(skip_mode, 1'b0, "R9 exit wins");
    edges(2);
    chk(hs_req, 1'b0, "R9 no pulse launched");
    chk(ls_en, 1'b1, "R4 PWM low side follows cmd");

    // R10: fresh run of 8 needed
    for (int i = 0; i < 7; i++) sw_cycle(1'b1);
    chk(skip_mode, 1'b0, "R10 seven not enough");
    sw_cycle(1'b1);
    chk(skip_mode, 1'b1, "R10 eighth enters");

    // R1: dropping enable leaves skip
    skip_en = 1'b0;
    edges(1);
    chk(skip_mode, 1'b0, "R1 enable drop exits");

    // R4: PWM follows command
    pwm_hs_cmd = 1'b1;
    edges(4);
    chk(hs_req, 1'b1, "R4 hs follows cmd");
    chk(ls_en, 1'b0, "R4 ls off with cmd");
    pwm_hs_cmd = 1'b0;
    edges(1);
    chk(hs_req, 1'b0, "R4 hs drops");
    edges(1);
    chk(ls_en, 1'b1, "R4 ls returns");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule